// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block takes interrupt requests from a set of hardware lines and from a software trigger, decides which one is approved, and then runs the entry sequence for it. Each hardware line comes with a pending flag and an enable bit held in registers outside the block, and one global mask bit gates all maskable lines. A parameter marks some lines as nonmaskable. Nonmaskable lines and software requests are approved in the cycle they are seen.

Once a request is approved, the block sends strobes that clear the serviced flag and set the global mask. It then holds a flush request to the pipeline until the current instruction reports that it is done. Next it writes thirteen context registers, one per accepted transfer, through a valid/ready write port whose address starts at the supplied stack pointer and steps by one. When the last register has been accepted, it presents the approved interrupt number for one cycle with a valid pulse. No further request is approved until that pulse has gone out.

Top module: `irq_entry_seq`

## Requirements
- R1: A software request (`sw_req_i`=1) is approved in an idle cycle whatever the pending flags, enable bits or global mask are. The approved number is `sw_num_i`, and no flag-clear bit is driven for it.
- R2: A pending hardware line whose bit is set in the `NMI_LINES` parameter is approved even when its enable bit is 0 and the global mask is 1.
- R3: A pending maskable line is approved only when its enable bit is 1 and `gmask_i` is 0. Otherwise nothing is approved.
- R4: Priority runs from software request, then nonmaskable lines, then maskable lines. Within each hardware group the lower line index wins.
- R5: In the approval cycle, `gmask_set_o` is 1 and `flag_clr_o` has exactly the bit of the approved hardware line set (all zero for a software request). In every other cycle both are 0.
- R6: From the cycle after approval, `flush_o` stays at 1 until `instr_done_i` is sampled high. No push is offered while `flush_o` is 1.
- R7: Thirteen pushes follow, in slot order 0 to 12: status word 0, temp, acc low, acc high, product low, product high, aux 0, aux 1, page, status word 1, debug status, program counter, enable register. Push k carries bits [k*DATA_W +: DATA_W] of `ctx_i`.
- R8: The first push address equals `sp_i` as sampled in the approval cycle, and each accepted push raises the address by 1.
- R9: While `push_ready_i` is 0, `push_valid_o` stays at 1 and the address and slot stay unchanged.
- R10: `vec_valid_o` is 1 for exactly one cycle, the cycle after the thirteenth push is accepted, with `vec_num_o` equal to the approved number. No approval is made from the approval cycle up to and including that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_flag_i | input | NUM_LINES | Pending flag per hardware line |
| irq_en_i | input | NUM_LINES | Enable bit per hardware line |
| gmask_i | input | 1 | Global mask for maskable lines (1 blocks them) |
| sw_req_i | input | 1 | Software interrupt request |
| sw_num_i | input | IDX_W | Interrupt number of the software request |
| ctx_i | input | 13*DATA_W | Current context registers, slot k at bits k*DATA_W |
| sp_i | input | ADDR_W | Current stack pointer |
| instr_done_i | input | 1 | Current instruction has completed |
| push_ready_i | input | 1 | Stack write port accepts a word |
| flag_clr_o | output | NUM_LINES | Clear strobe for the serviced flag |
| gmask_set_o | output | 1 | Strobe that sets the global mask |
| flush_o | output | 1 | Finish current instruction and flush younger work |
| push_valid_o | output | 1 | Stack write valid |
| push_addr_o | output | ADDR_W | Stack write address |
| push_data_o | output | DATA_W | Stack write data |
| vec_valid_o | output | 1 | Vector number valid pulse |
| vec_num_o | output | IDX_W | Approved interrupt number |

## Verification
The assertions check on every cycle that the flag-clear strobe never has more than one bit set, that flush and push never overlap, that a stalled push keeps its address, that accepted pushes step the address, and that the vector pulse follows the final push and lasts a single cycle. Only the bench scenarios can show which request wins for a given mix of flags, enables, mask and software trigger, that the pushed words come in the fixed slot order, and that requests arriving mid-sequence are held off.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  // Number of context words saved on entry; slot order is fixed by R7.
  localparam int CTX_SLOTS = 13;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_PUSH  = 2'd2,
    ST_VEC   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0] NMI_LINES = '0,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0] flag_i,
  input  logic [NUM_LINES-1:0] en_i,
  input  logic                 gmask_i,
  input  logic                 sw_req_i,
  input  logic [IDX_W-1:0]     sw_num_i,
  output logic                 grant_o,
  output logic [IDX_W-1:0]     num_o,
  output logic [NUM_LINES-1:0] clr_o
);
  logic             nmi_hit, mk_hit;
  logic [IDX_W-1:0] nmi_idx, mk_idx;

  // Scan from the top so the lowest index is written last and wins (R4).
  always_comb begin
    nmi_hit = 1'b0;
    mk_hit  = 1'b0;
    nmi_idx = '0;
    mk_idx  = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (flag_i[i] && NMI_LINES[i]) begin
        nmi_hit = 1'b1;
        nmi_idx = IDX_W'(i);
      end
      if (flag_i[i] && !NMI_LINES[i] && en_i[i] && !gmask_i) begin
        mk_hit = 1'b1;
        mk_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    grant_o = sw_req_i | nmi_hit | mk_hit;
    clr_o   = '0;
    if (sw_req_i) begin
      num_o = sw_num_i;
    end else if (nmi_hit) begin
      num_o = nmi_idx;
      clr_o[nmi_idx] = 1'b1;
    end else begin
      num_o = mk_idx;
      clr_o[mk_idx] = mk_hit;
    end
  end
endmodule

// File: rtl/irq_push_engine.sv
module irq_push_engine #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int SLOTS  = 13,
  localparam int CNT_W = $clog2(SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [ADDR_W-1:0]       sp_i,
  input  logic                    advance_i,
  input  logic [SLOTS*DATA_W-1:0] ctx_i,
  output logic [ADDR_W-1:0]       addr_o,
  output logic [DATA_W-1:0]       data_o,
  output logic                    last_o
);
  logic [CNT_W-1:0]  slot_q, slot_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    slot_d = slot_q;
    addr_d = addr_q;
    if (start_i) begin
      slot_d = '0;
      addr_d = sp_i;
    end else if (advance_i) begin
      slot_d = slot_q + 1'b1;
      addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      addr_q <= '0;
    end else if (start_i || advance_i) begin
      slot_q <= slot_d;
      addr_q <= addr_d;
    end
  end

  assign last_o = (slot_q == CNT_W'(SLOTS - 1));
  assign addr_o = addr_q;
  assign data_o = ctx_i[slot_q*DATA_W +: DATA_W];
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0] NMI_LINES = 8'b0100_0000,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LINES-1:0]        irq_flag_i,
  input  logic [NUM_LINES-1:0]        irq_en_i,
  input  logic                        gmask_i,
  input  logic                        sw_req_i,
  input  logic [IDX_W-1:0]            sw_num_i,
  input  logic [CTX_SLOTS*DATA_W-1:0] ctx_i,
  input  logic [ADDR_W-1:0]           sp_i,
  input  logic                        instr_done_i,
  input  logic                        push_ready_i,
  output logic [NUM_LINES-1:0]        flag_clr_o,
  output logic                        gmask_set_o,
  output logic                        flush_o,
  output logic                        push_valid_o,
  output logic [ADDR_W-1:0]           push_addr_o,
  output logic [DATA_W-1:0]           push_data_o,
  output logic                        vec_valid_o,
  output logic [IDX_W-1:0]            vec_num_o
);
  // Reset asserts at once and releases on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ok = rst_pipe_q[1];

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] vec_q;
  logic             grant, idle, approve, advance, last;
  logic [IDX_W-1:0] win_num;
  logic [NUM_LINES-1:0] win_clr;

  irq_arbiter #(.NUM_LINES(NUM_LINES), .NMI_LINES(NMI_LINES)) u_arb (
    .flag_i  (irq_flag_i),
    .en_i    (irq_en_i),
    .gmask_i (gmask_i),
    .sw_req_i(sw_req_i),
    .sw_num_i(sw_num_i),
    .grant_o (grant),
    .num_o   (win_num),
    .clr_o   (win_clr)
  );

  assign idle    = (state_q == ST_IDLE);
  assign approve = idle && grant;
  assign advance = (state_q == ST_PUSH) && push_ready_i;

  irq_push_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SLOTS(CTX_SLOTS)) u_push (
    .clk      (clk),
    .rst_n    (rst_ok),
    .start_i  (approve),
    .sp_i     (sp_i),
    .advance_i(advance),
    .ctx_i    (ctx_i),
    .addr_o   (push_addr_o),
    .data_o   (push_data_o),
    .last_o   (last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (grant)        state_d = ST_DRAIN;
      ST_DRAIN: if (instr_done_i) state_d = ST_PUSH;
      ST_PUSH:  if (advance && last) state_d = ST_VEC;
      ST_VEC:                     state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)      vec_q <= '0;
    else if (approve) vec_q <= win_num;
  end

  assign flag_clr_o   = approve ? win_clr : '0;
  assign gmask_set_o  = approve;
  assign flush_o      = (state_q == ST_DRAIN);
  assign push_valid_o = (state_q == ST_PUSH);
  assign vec_valid_o  = (state_q == ST_VEC);
  assign vec_num_o    = vec_q;

  // R5: at most one flag is cleared per approval
  p_clr_onehot_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0(flag_clr_o));
  // R6: no push is offered while the flush is outstanding
  p_flush_excl_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    flush_o |-> !push_valid_o);
  // R9: a refused push stays offered at the same address
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (push_valid_o && !push_ready_i) |=> (push_valid_o && $stable(push_addr_o)));
  // R8: an accepted push that is not the last moves the address up by one
  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    (push_valid_o && push_ready_i && !last) |=>
      (push_addr_o == $past(push_addr_o) + 1'b1));
  // R10: vector follows the final accepted push
  p_vec_follow_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    (push_valid_o && push_ready_i && last) |=> vec_valid_o);
  // R10: vector valid is a single-cycle pulse
  p_vec_pulse_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    vec_valid_o |=> !vec_valid_o);
  // R10: no approval strobe while a sequence is running
  p_no_regrant_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    (flush_o || push_valid_o || vec_valid_o) |-> !gmask_set_o);
endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  localparam int NL = 8;
  localparam int DW = 16;
  localparam int AW = 16;
  localparam int IW = 3;
  localparam int NS = 13;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NL-1:0] irq_flag_i, irq_en_i;
  logic          gmask_i, sw_req_i;
  logic [IW-1:0] sw_num_i;
  logic [NS*DW-1:0] ctx_i;
  logic [AW-1:0] sp_i;
  logic          instr_done_i, push_ready_i;
  logic [NL-1:0] flag_clr_o;
  logic          gmask_set_o, flush_o, push_valid_o, vec_valid_o;
  logic [AW-1:0] push_addr_o;
  logic [DW-1:0] push_data_o;
  logic [IW-1:0] vec_num_o;

  irq_entry_seq #(.NUM_LINES(NL), .NMI_LINES(8'b0100_0000), .DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_flag_i(irq_flag_i), .irq_en_i(irq_en_i),
    .gmask_i(gmask_i), .sw_req_i(sw_req_i), .sw_num_i(sw_num_i), .ctx_i(ctx_i),
    .sp_i(sp_i), .instr_done_i(instr_done_i), .push_ready_i(push_ready_i),
    .flag_clr_o(flag_clr_o), .gmask_set_o(gmask_set_o), .flush_o(flush_o),
    .push_valid_o(push_valid_o), .push_addr_o(push_addr_o), .push_data_o(push_data_o),
    .vec_valid_o(vec_valid_o), .vec_num_o(vec_num_o)
  );

  always #10 clk = ~clk; // 50 MHz

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct packed {
    logic [7:0] flags;
    logic [7:0] en;
    logic       gm;
    logic       sw;
    logic [2:0] swn;
    logic       grant;
    logic [2:0] num;
    logic [7:0] clr;
  } vec_t;

  // Line 6 is the only nonmaskable line.
  localparam vec_t VECS [9] = '{
    '{8'h00, 8'hFF, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00}, // R3 nothing pending
    '{8'h08, 8'h08, 1'b0, 1'b0, 3'd0, 1'b1, 3'd3, 8'h08}, // R3 enabled maskable
    '{8'h08, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00}, // R3 disabled
    '{8'h08, 8'h08, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00}, // R3 masked
    '{8'h40, 8'h00, 1'b1, 1'b0, 3'd0, 1'b1, 3'd6, 8'h40}, // R2 nonmaskable
    '{8'h14, 8'h14, 1'b0, 1'b0, 3'd0, 1'b1, 3'd2, 8'h04}, // R4 lower index
    '{8'h41, 8'h01, 1'b0, 1'b0, 3'd0, 1'b1, 3'd6, 8'h40}, // R4 nmi over maskable
    '{8'h00, 8'h00, 1'b1, 1'b1, 3'd5, 1'b1, 3'd5, 8'h00}, // R1 software
    '{8'h40, 8'hFF, 1'b0, 1'b1, 3'd7, 1'b1, 3'd7, 8'h00}  // R4 software wins
  };

  function automatic logic [DW-1:0] ctx_val(int k);
    return 16'hC000 + 16'(k) * 16'h0111;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic idle_inputs();
    irq_flag_i = '0; irq_en_i = '0; gmask_i = 1'b0;
    sw_req_i = 1'b0; sw_num_i = '0;
  endtask

  // Called at a negedge in the approval cycle, after the approval check.
  task automatic run_entry(input logic [2:0] exp_num, input logic [AW-1:0] sp,
                           input bit stall, input bit busy_noise);
    logic [AW-1:0] held;
    @(posedge clk); @(negedge clk);
    if (busy_noise) begin
      irq_flag_i = 8'hFF; irq_en_i = 8'hFF; sw_req_i = 1'b1; sw_num_i = 3'd1;
      gmask_i = 1'b0;
    end else idle_inputs();
    for (int w = 0; w < 3; w++) begin
      chk(flush_o && !push_valid_o, "R6 flush held, no push", {flush_o, push_valid_o}, 2'b10);
      chk(!gmask_set_o && flag_clr_o == 0, "R10 no approval while busy", gmask_set_o, 0);
      if (w == 2) instr_done_i = 1'b1;
      @(posedge clk); @(negedge clk);
    end
    instr_done_i = 1'b0;
    for (int k = 0; k < NS; k++) begin
      if (stall && (k % 4 == 1)) begin
        push_ready_i = 1'b0;
        held = push_addr_o;
        @(posedge clk); @(negedge clk);
        chk(push_valid_o && push_addr_o == held, "R9 stall holds push", push_addr_o, held);
        push_ready_i = 1'b1;
      end
      chk(push_valid_o && !flush_o, "R6 push after done", push_valid_o, 1);
      chk(push_data_o == ctx_val(k), "R7 push data slot", push_data_o, ctx_val(k));
      chk(push_addr_o == sp + AW'(k), "R8 push address", push_addr_o, sp + AW'(k));
      if (busy_noise) chk(!gmask_set_o, "R10 no approval while pushing", gmask_set_o, 0);
      @(posedge clk); @(negedge clk);
    end
    chk(vec_valid_o && !push_valid_o, "R10 vector valid", vec_valid_o, 1);
    chk(vec_num_o == exp_num, "R10 vector number", vec_num_o, exp_num);
    if (busy_noise) chk(!gmask_set_o, "R10 no approval in vector cycle", gmask_set_o, 0);
    idle_inputs();
    @(posedge clk); @(negedge clk);
    chk(!vec_valid_o, "R10 vector pulse ends", vec_valid_o, 0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    instr_done_i = 1'b0; push_ready_i = 1'b1; sp_i = 16'h0200;
    for (int k = 0; k < NS; k++) ctx_i[k*DW +: DW] = ctx_val(k);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    chk(!flush_o && !push_valid_o && !vec_valid_o && !gmask_set_o && flag_clr_o == 0,
        "R5 reset outputs quiet", {flush_o, push_valid_o, vec_valid_o, gmask_set_o}, 0);

    // Vector table
    for (int v = 0; v < 9; v++) begin
      irq_flag_i = VECS[v].flags; irq_en_i = VECS[v].en; gmask_i = VECS[v].gm;
      sw_req_i = VECS[v].sw; sw_num_i = VECS[v].swn;
      sp_i = 16'h0300 + 16'(v) * 16'h20;
      #1;
      chk(gmask_set_o == VECS[v].grant, "R1 R2 R3 R4 approval decision", gmask_set_o, VECS[v].grant);
      chk(flag_clr_o == VECS[v].clr, "R5 flag clear strobe", flag_clr_o, VECS[v].clr);
      if (VECS[v].grant) run_entry(VECS[v].num, sp_i, 1'b0, 1'b0);
      else begin
        @(posedge clk); @(negedge clk);
        chk(!flush_o, "R3 blocked request starts nothing", flush_o, 0);
        idle_inputs();
      end
    end

    // Stalls on the push port, with the stack pointer near wraparound
    irq_flag_i = 8'h02; irq_en_i = 8'h02; sp_i = 16'hFFFA; #1;
    chk(gmask_set_o && flag_clr_o == 8'h02, "R5 approval strobes", flag_clr_o, 8'h02);
    run_entry(3'd1, 16'hFFFA, 1'b1, 1'b0);

    // Requests during a running sequence are held off
    irq_flag_i = 8'h80; irq_en_i = 8'h80; sp_i = 16'h0040; #1;
    chk(gmask_set_o && flag_clr_o == 8'h80, "R4 highest index alone", flag_clr_o, 8'h80);
    run_entry(3'd7, 16'h0040, 1'b0, 1'b1);

    // The next request is approved once the sequence has returned to idle
    sw_req_i = 1'b1; sw_num_i = 3'd2; #1;
    chk(gmask_set_o && flag_clr_o == 0, "R1 approval after sequence", gmask_set_o, 1);
    run_entry(3'd2, 16'h0040, 1'b1, 1'b0);

    summary();
  end
endmodule